// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Vectoring

This block is the interrupt front end of an 8-bit processor core. It gathers five request sources: a non-maskable trap, three restart requests of descending rank (r75, r65, r55) and a general request line whose instruction comes from the interrupting device. Whenever the core signals an instruction boundary, the block picks at most one request, the highest-ranked one that is eligible. One cycle later it raises a single-cycle `take_o` together with the information the core needs to service it: the target address, whether the return address has to be pushed, the saved PC, the cycle cost and the bus status code. A device-supplied instruction that is neither a call nor a jump is instead handed to the core as an opcode to execute.

The trap and r75 inputs act on rising edges, which are latched until the request is serviced. The r65, r55 and general inputs are levels, sampled at the boundary. The block also holds the mask and enable state. The core writes this state with a set-mask command and with enable/disable strobes, and reads it back through a registered read-mask port. A serviced trap snapshots the enable state, and the next mask read reports that snapshot once. All inputs are taken to be synchronous to `clk_i`.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A rising edge on `trap_i` sets a trap pending flag that stays set until serviced. The trap is taken regardless of the enable and all masks. A level held high after service does not retrigger. Out of reset, the previous sample of the input reads as low.
- R2: A rising edge on `rst75_i` sets a latched r75 pending bit. This bit is visible in bit 6 of the mask read and clears when the r75 request is taken.
- R3: At one boundary at most one request is taken, in the fixed order trap, r75, r65, r55, general.
- R4: A restart source is eligible only when its mask bit is 0 and the enable is 1. The general line needs only the enable. The `rst65_i`, `rst55_i` and `intr_i` levels are sampled in the boundary cycle.
- R5: `take_o` is high for exactly the cycle after an `at_boundary_i` cycle that found an eligible request. For the trap, r75, r65 and r55 sources, `vector_o` is 0x0024, 0x003C, 0x0034 and 0x002C respectively, with `push_pc_o`=1 and `cycles_o`=11.
- R6: Taking any request clears the enable, so `inte_o` is 0 in the `take_o` cycle. `en_set_i` sets the enable and `en_clr_i` clears it, each acting one cycle later.
- R7: If `halted_i` is high at acceptance, then `saved_pc_o`=`pc_i`+1, `halt_exit_o`=1 and `status_o`=0x26. Otherwise `saved_pc_o`=`pc_i`, `halt_exit_o`=0 and `status_o`=0x23.
- R8: A taken trap stores the enable state from before the trap. The first mask read afterwards reports the stored state in bit 3 and consumes it, and later reads report the live enable.
- R9: Reset sets all three masks, clears the enable, the r75 pending bit, the trap pending flag and the snapshot, and drives `sod_o` low. A mask read then returns 0x07.
- R10: For the general line, `intr_vec_i`[23:16]=0xCD gives a call: `vector_o`=`intr_vec_i`[15:0], `push_pc_o`=1, `cycles_o`=17. A value of 0xC3 gives a jump with the same target, `push_pc_o`=0 and `cycles_o`=10. Any other top byte gives `is_opcode_o`=1 and `opcode_o`=`intr_vec_i`[7:0], with `push_pc_o`=0 and `cycles_o`=0.
- R11: A set-mask write with data bit 3 set loads the masks from bits 2:0 (bit 0 r55, bit 1 r65, bit 2 r75); with bit 3 clear the masks are unchanged. Data bit 4 clears the r75 pending bit. Data bit 6 loads `sod_o` from data bit 7.
- R12: A pulse on `rd_mask_i` loads `mask_rd_o` one cycle later. The fields are: masks in bits 2:0 in the R11 order, enable in bit 3, the `rst55_i` level in bit 4, the `rst65_i` level in bit 5, r75 pending in bit 6, and `sid_i` in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Non-maskable trap request, rising-edge |
| rst75_i | input | 1 | Restart request r75, rising-edge |
| rst65_i | input | 1 | Restart request r65, level |
| rst55_i | input | 1 | Restart request r55, level |
| intr_i | input | 1 | General request, level |
| intr_vec_i | input | 24 | Instruction supplied by the device for the general request |
| at_boundary_i | input | 1 | Instruction-boundary strobe from the core |
| halted_i | input | 1 | Core is in the halt state |
| pc_i | input | 16 | Current program counter |
| en_set_i | input | 1 | Enable-interrupts strobe |
| en_clr_i | input | 1 | Disable-interrupts strobe |
| wr_mask_i | input | 1 | Set-mask command strobe |
| wr_data_i | input | 8 | Set-mask command data |
| rd_mask_i | input | 1 | Read-mask strobe |
| sid_i | input | 1 | Serial input data level |
| take_o | output | 1 | Request accepted, one cycle |
| vector_o | output | 16 | Target address |
| push_pc_o | output | 1 | Push the saved PC |
| saved_pc_o | output | 16 | Return address to push |
| is_opcode_o | output | 1 | Execute `opcode_o` instead of jumping |
| opcode_o | output | 8 | Device-supplied opcode |
| cycles_o | output | 5 | Cycle cost of the entry |
| status_o | output | 8 | Bus status code for the acknowledge |
| halt_exit_o | output | 1 | Acceptance left the halt state |
| inte_o | output | 1 | Interrupt enable state |
| sod_o | output | 1 | Serial output data |
| mask_rd_o | output | 8 | Mask read result |

## Verification
The bench builds the block with its default widths: a 16-bit PC, a 5-bit cycle count and 8-bit opcodes, which gives a 24-bit device vector. At these widths every fixed code can be compared directly: the restart addresses, the 0xCD/0xC3 prefixes, the 0x23/0x26 status codes and the 11/17/10 cycle costs. The PC increment on halt exit is exercised on a 16-bit value, and all eight fields of the read word are covered. Directed scenarios stack several sources at once to walk the whole priority chain, hold the edge inputs high to show they do not retrigger, and read the mask twice after a trap to see the snapshot consumed.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [2:0] {
    SRC_NONE, SRC_TRAP, SRC_R75, SRC_R65, SRC_R55, SRC_INTR
  } irq_src_e;

  localparam logic [15:0] VEC_TRAP = 16'h0024;
  localparam logic [15:0] VEC_R75  = 16'h003C;
  localparam logic [15:0] VEC_R65  = 16'h0034;
  localparam logic [15:0] VEC_R55  = 16'h002C;

  localparam logic [7:0] PFX_CALL = 8'hCD;
  localparam logic [7:0] PFX_JUMP = 8'hC3;

  localparam logic [7:0] ST_ACK      = 8'h23;
  localparam logic [7:0] ST_ACK_HALT = 8'h26;

  localparam int CYC_RESTART = 11;
  localparam int CYC_CALL    = 17;
  localparam int CYC_JUMP    = 10;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      // a new edge wins over a clear in the same cycle
      if (lvl_i && !prev_q) pend_o <= 1'b1;
      else if (clr_i)       pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int NUM_RST = 3,
  parameter int DAT_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [DAT_W-1:0]   wr_data_i,
  input  logic               en_set_i,
  input  logic               en_clr_i,
  input  logic               accept_i,
  input  logic               trap_accept_i,
  input  logic               rd_i,
  input  logic               pend75_i,
  input  logic               lvl65_i,
  input  logic               lvl55_i,
  input  logic               sid_i,
  output logic [NUM_RST-1:0] masks_o,
  output logic               ie_o,
  output logic               sod_o,
  output logic               clr75_o,
  output logic [DAT_W-1:0]   rd_data_o
);
  localparam int BIT_MSE  = NUM_RST;
  localparam int BIT_CLR  = NUM_RST + 1;
  localparam int BIT_SOE  = DAT_W - 2;
  localparam int BIT_SODV = DAT_W - 1;

  logic snap_v_q, snap_ie_q;

  assign clr75_o = wr_i && wr_data_i[BIT_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      masks_o   <= '1;
      ie_o      <= 1'b0;
      sod_o     <= 1'b0;
      snap_v_q  <= 1'b0;
      snap_ie_q <= 1'b0;
      rd_data_o <= '0;
    end else begin
      if (wr_i && wr_data_i[BIT_MSE]) masks_o <= wr_data_i[NUM_RST-1:0];
      if (wr_i && wr_data_i[BIT_SOE]) sod_o <= wr_data_i[BIT_SODV];

      if (accept_i)      ie_o <= 1'b0;
      else if (en_set_i) ie_o <= 1'b1;
      else if (en_clr_i) ie_o <= 1'b0;

      if (rd_i) begin
        rd_data_o <= {sid_i, pend75_i, lvl65_i, lvl55_i,
                      snap_v_q ? snap_ie_q : ie_o, masks_o};
      end

      if (trap_accept_i) begin
        snap_v_q  <= 1'b1;
        snap_ie_q <= ie_o;
      end else if (rd_i) begin
        snap_v_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int CYC_W   = 5,
  parameter int OP_W    = 8,
  parameter int NUM_RST = 3,
  localparam int IV_W   = OP_W + PC_W
) (
  input  logic               eval_i,
  input  logic               trap_pend_i,
  input  logic               pend75_i,
  input  logic               lvl65_i,
  input  logic               lvl55_i,
  input  logic               intr_i,
  input  logic [NUM_RST-1:0] masks_i,
  input  logic               ie_i,
  input  logic               halted_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [IV_W-1:0]    intr_vec_i,
  output irq_src_e           grant_o,
  output logic [PC_W-1:0]    vector_o,
  output logic               push_o,
  output logic               is_op_o,
  output logic [OP_W-1:0]    opcode_o,
  output logic [CYC_W-1:0]   cycles_o,
  output logic [7:0]         status_o,
  output logic [PC_W-1:0]    saved_pc_o
);
  logic [OP_W-1:0] prefix;
  assign prefix = intr_vec_i[IV_W-1 -: OP_W];

  always_comb begin
    grant_o = SRC_NONE;
    if (eval_i) begin
      if (trap_pend_i)                         grant_o = SRC_TRAP;
      else if (ie_i && pend75_i && !masks_i[2]) grant_o = SRC_R75;
      else if (ie_i && lvl65_i  && !masks_i[1]) grant_o = SRC_R65;
      else if (ie_i && lvl55_i  && !masks_i[0]) grant_o = SRC_R55;
      else if (ie_i && intr_i)                 grant_o = SRC_INTR;
    end
  end

  always_comb begin
    vector_o = '0;
    push_o   = 1'b0;
    is_op_o  = 1'b0;
    opcode_o = '0;
    cycles_o = '0;
    unique case (grant_o)
      SRC_TRAP: begin vector_o = PC_W'(VEC_TRAP); push_o = 1'b1; cycles_o = CYC_W'(CYC_RESTART); end
      SRC_R75:  begin vector_o = PC_W'(VEC_R75);  push_o = 1'b1; cycles_o = CYC_W'(CYC_RESTART); end
      SRC_R65:  begin vector_o = PC_W'(VEC_R65);  push_o = 1'b1; cycles_o = CYC_W'(CYC_RESTART); end
      SRC_R55:  begin vector_o = PC_W'(VEC_R55);  push_o = 1'b1; cycles_o = CYC_W'(CYC_RESTART); end
      SRC_INTR: begin
        if (prefix == OP_W'(PFX_CALL)) begin
          vector_o = intr_vec_i[PC_W-1:0];
          push_o   = 1'b1;
          cycles_o = CYC_W'(CYC_CALL);
        end else if (prefix == OP_W'(PFX_JUMP)) begin
          vector_o = intr_vec_i[PC_W-1:0];
          cycles_o = CYC_W'(CYC_JUMP);
        end else begin
          is_op_o  = 1'b1;
          opcode_o = intr_vec_i[OP_W-1:0];
        end
      end
      default: ;
    endcase
  end

  assign status_o   = halted_i ? ST_ACK_HALT : ST_ACK;
  assign saved_pc_o = halted_i ? pc_i + PC_W'(1) : pc_i;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CYC_W = 5,
  parameter int OP_W  = 8,
  localparam int IV_W = OP_W + PC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_i,
  input  logic             rst75_i,
  input  logic             rst65_i,
  input  logic             rst55_i,
  input  logic             intr_i,
  input  logic [IV_W-1:0]  intr_vec_i,
  input  logic             at_boundary_i,
  input  logic             halted_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic             wr_mask_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_mask_i,
  input  logic             sid_i,
  output logic             take_o,
  output logic [PC_W-1:0]  vector_o,
  output logic             push_pc_o,
  output logic [PC_W-1:0]  saved_pc_o,
  output logic             is_opcode_o,
  output logic [OP_W-1:0]  opcode_o,
  output logic [CYC_W-1:0] cycles_o,
  output logic [7:0]       status_o,
  output logic             halt_exit_o,
  output logic             inte_o,
  output logic             sod_o,
  output logic [7:0]       mask_rd_o
);
  localparam int NUM_RST = 3;

  irq_src_e            grant;
  logic                trap_pend, pend75, clr75_wr, ie;
  logic [NUM_RST-1:0]  masks;
  logic [PC_W-1:0]     a_vector, a_saved_pc;
  logic                a_push, a_is_op;
  logic [OP_W-1:0]     a_opcode;
  logic [CYC_W-1:0]    a_cycles;
  logic [7:0]          a_status;

  irq_edge_latch u_trap (
    .clk_i, .rst_ni, .lvl_i(trap_i), .clr_i(grant == SRC_TRAP), .pend_o(trap_pend)
  );

  irq_edge_latch u_r75 (
    .clk_i, .rst_ni, .lvl_i(rst75_i),
    .clr_i((grant == SRC_R75) || clr75_wr), .pend_o(pend75)
  );

  irq_mask_regs #(.NUM_RST(NUM_RST), .DAT_W(8)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(wr_mask_i), .wr_data_i,
    .en_set_i, .en_clr_i,
    .accept_i(grant != SRC_NONE), .trap_accept_i(grant == SRC_TRAP),
    .rd_i(rd_mask_i), .pend75_i(pend75), .lvl65_i(rst65_i), .lvl55_i(rst55_i),
    .sid_i,
    .masks_o(masks), .ie_o(ie), .sod_o, .clr75_o(clr75_wr), .rd_data_o(mask_rd_o)
  );

  irq_arbiter #(.PC_W(PC_W), .CYC_W(CYC_W), .OP_W(OP_W), .NUM_RST(NUM_RST)) u_arb (
    .eval_i(at_boundary_i), .trap_pend_i(trap_pend), .pend75_i(pend75),
    .lvl65_i(rst65_i), .lvl55_i(rst55_i), .intr_i,
    .masks_i(masks), .ie_i(ie), .halted_i, .pc_i, .intr_vec_i,
    .grant_o(grant), .vector_o(a_vector), .push_o(a_push), .is_op_o(a_is_op),
    .opcode_o(a_opcode), .cycles_o(a_cycles), .status_o(a_status),
    .saved_pc_o(a_saved_pc)
  );

  assign inte_o = ie;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o      <= 1'b0;
      vector_o    <= '0;
      push_pc_o   <= 1'b0;
      saved_pc_o  <= '0;
      is_opcode_o <= 1'b0;
      opcode_o    <= '0;
      cycles_o    <= '0;
      status_o    <= '0;
      halt_exit_o <= 1'b0;
    end else begin
      take_o <= (grant != SRC_NONE);
      if (grant != SRC_NONE) begin
        vector_o    <= a_vector;
        push_pc_o   <= a_push;
        saved_pc_o  <= a_saved_pc;
        is_opcode_o <= a_is_op;
        opcode_o    <= a_opcode;
        cycles_o    <= a_cycles;
        status_o    <= a_status;
        halt_exit_o <= halted_i;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int PC_W  = 16,
  parameter int CYC_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             at_boundary_i,
  input logic [PC_W-1:0]  pc_i,
  input logic             take_o,
  input logic [PC_W-1:0]  vector_o,
  input logic             push_pc_o,
  input logic [PC_W-1:0]  saved_pc_o,
  input logic [CYC_W-1:0] cycles_o,
  input logic             halt_exit_o,
  input logic             inte_o
);
  a_r5_take_after_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(at_boundary_i));

  a_r6_enable_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !inte_o);

  // only the trap entry may be taken without the enable
  a_r4_enable_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !(vector_o == PC_W'(16'h0024) && cycles_o == CYC_W'(11))) |-> $past(inte_o));

  a_r7_halt_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && halt_exit_o) |-> (saved_pc_o == $past(pc_i) + PC_W'(1)));

  a_r10_jump_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cycles_o == CYC_W'(10)) |-> !push_pc_o);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.PC_W(PC_W), .CYC_W(CYC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .at_boundary_i(at_boundary_i), .pc_i(pc_i),
  .take_o(take_o), .vector_o(vector_o), .push_pc_o(push_pc_o),
  .saved_pc_o(saved_pc_o), .cycles_o(cycles_o), .halt_exit_o(halt_exit_o),
  .inte_o(inte_o)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trap_i = 0, rst75_i = 0, rst65_i = 0, rst55_i = 0, intr_i = 0;
  logic [23:0] intr_vec_i = '0;
  logic        at_boundary_i = 0, halted_i = 0;
  logic [15:0] pc_i = '0;
  logic        en_set_i = 0, en_clr_i = 0, wr_mask_i = 0, rd_mask_i = 0, sid_i = 0;
  logic [7:0]  wr_data_i = '0;
  logic        take_o, push_pc_o, is_opcode_o, halt_exit_o, inte_o, sod_o;
  logic [15:0] vector_o, saved_pc_o;
  logic [7:0]  opcode_o, status_o, mask_rd_o;
  logic [4:0]  cycles_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  irq_prio_ctrl dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic boundary();
    at_boundary_i = 1; tick(); at_boundary_i = 0;
  endtask

  task automatic rd_mask(output logic [7:0] v);
    rd_mask_i = 1; tick(); rd_mask_i = 0; v = mask_rd_o;
  endtask

  task automatic wr_mask(input logic [7:0] d);
    wr_mask_i = 1; wr_data_i = d; tick(); wr_mask_i = 0;
  endtask

  task automatic ei();
    en_set_i = 1; tick(); en_set_i = 0;
  endtask

  task automatic pulse75();
    rst75_i = 1; tick(); rst75_i = 0; tick();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R9 take", take_o, 0);
    check("R9 inte", inte_o, 0);
    check("R9 sod", sod_o, 0);
    rd_mask(v);
    check("R9 mask read", v, 8'h07);
  endtask

  task automatic t_trap();
    logic [7:0] v;
    ei();
    trap_i = 1; tick();
    boundary();
    check("R1 take", take_o, 1);
    check("R5 trap vector", vector_o, 16'h0024);
    check("R5 trap push", push_pc_o, 1);
    check("R5 trap cycles", cycles_o, 11);
    check("R7 status", status_o, 8'h23);
    check("R6 inte low", inte_o, 0);
    boundary();
    check("R1 held level no retrigger", take_o, 0);
    rd_mask(v);
    check("R8 first read snapshot", v, 8'h0F);
    rd_mask(v);
    check("R8 second read live", v, 8'h07);
    trap_i = 0; tick();
    trap_i = 1; tick();
    boundary();
    check("R1 trap ignores enable", take_o, 1);
    check("R1 trap vector", vector_o, 16'h0024);
    trap_i = 0; tick();
    rd_mask(v);
    check("R8 snapshot of disabled", v, 8'h07);
  endtask

  task automatic t_r75();
    logic [7:0] v;
    wr_mask(8'h08);
    pulse75();
    rd_mask(v);
    check("R2 pending visible", v, 8'h40);
    boundary();
    check("R4 no take without enable", take_o, 0);
    ei();
    boundary();
    check("R2 take r75", take_o, 1);
    check("R5 r75 vector", vector_o, 16'h003C);
    check("R5 r75 cycles", cycles_o, 11);
    rd_mask(v);
    check("R2 pending cleared on take", v, 8'h00);
    pulse75();
    wr_mask(8'h18);
    rd_mask(v);
    check("R11 write clears pending", v, 8'h00);
    wr_mask(8'h0C);
    pulse75();
    ei();
    boundary();
    check("R4 masked r75", take_o, 0);
    rd_mask(v);
    check("R12 read fields", v, 8'h4C);
    wr_mask(8'h18);
    en_clr_i = 1; tick(); en_clr_i = 0;
    check("R6 disable strobe", inte_o, 0);
  endtask

  task automatic t_priority();
    logic [7:0] v;
    wr_mask(8'h08);
    rst65_i = 1; rst55_i = 1; intr_i = 1; intr_vec_i = 24'hC30200;
    pulse75();
    ei();
    boundary();
    check("R3 r75 first", vector_o, 16'h003C);
    ei(); boundary();
    check("R3 r65 second", vector_o, 16'h0034);
    rst65_i = 0;
    ei(); boundary();
    check("R3 r55 third", vector_o, 16'h002C);
    rst55_i = 0;
    ei(); boundary();
    check("R3 general last", vector_o, 16'h0200);
    check("R10 jump no push", push_pc_o, 0);
    check("R10 jump cycles", cycles_o, 10);
    boundary();
    check("R4 general needs enable", take_o, 0);
    wr_mask(8'h0F);
    rst55_i = 1;
    ei(); boundary();
    check("R4 general ignores masks", vector_o, 16'h0200);
    check("R4 general take", take_o, 1);
    rst55_i = 0; intr_i = 0;
    wr_mask(8'h08);
    ei();
    trap_i = 1; rst75_i = 1; tick(); rst75_i = 0;
    boundary();
    check("R3 trap over r75", vector_o, 16'h0024);
    ei(); boundary();
    check("R3 r75 after trap", vector_o, 16'h003C);
    trap_i = 0;
    rd_mask(v);
    check("R8 snapshot enabled", v, 8'h08);
  endtask

  task automatic t_intr();
    wr_mask(8'h0F);
    intr_i = 1; intr_vec_i = 24'hCD1234;
    ei(); boundary();
    check("R10 call vector", vector_o, 16'h1234);
    check("R10 call push", push_pc_o, 1);
    check("R10 call cycles", cycles_o, 17);
    check("R10 call not opcode", is_opcode_o, 0);
    intr_vec_i = 24'h0000EF;
    ei(); boundary();
    check("R10 opcode flag", is_opcode_o, 1);
    check("R10 opcode value", opcode_o, 8'hEF);
    check("R10 opcode no push", push_pc_o, 0);
    intr_i = 0;
  endtask

  task automatic t_halt();
    wr_mask(8'h08);
    rst55_i = 1; halted_i = 1; pc_i = 16'h0100;
    ei(); boundary();
    check("R7 halt saved pc", saved_pc_o, 16'h0101);
    check("R7 halt status", status_o, 8'h26);
    check("R7 halt exit", halt_exit_o, 1);
    halted_i = 0; pc_i = 16'hFFF0;
    ei(); boundary();
    check("R7 run saved pc", saved_pc_o, 16'hFFF0);
    check("R7 run status", status_o, 8'h23);
    check("R7 run no exit", halt_exit_o, 0);
    rst55_i = 0;
  endtask

  task automatic t_sod();
    logic [7:0] v;
    wr_mask(8'h0A);
    wr_mask(8'hC5);
    check("R11 sod set", sod_o, 1);
    sid_i = 1;
    rd_mask(v);
    check("R11 masks held without bit3", v, 8'h82);
    wr_mask(8'h00);
    check("R11 sod unchanged without bit6", sod_o, 1);
    wr_mask(8'h40);
    check("R11 sod cleared", sod_o, 0);
    rst65_i = 1;
    rd_mask(v);
    check("R12 level bit5 and sid", v, 8'hA2);
    rst65_i = 0; sid_i = 0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_ni = 1;
    tick();
    t_reset();
    t_trap();
    t_r75();
    t_priority();
    t_intr();
    t_halt();
    t_sod();
    tick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule